// File: doc/BRIEF.md
# S/PDIF Biphase Receiver and Framer

This block receives a single-wire S/PDIF bitstream that carries two audio channels and turns it into left/right 24-bit linear PCM sample pairs. The line is oversampled by the fast system clock. The bit rate is set by `half_len_i`, the number of clock samples in one half time slot. This setting stands in for the external clock divider. The receiver measures the length of each run between line transitions and rounds it to 1, 2 or 3 half slots. It decodes biphase-mark data slots from those runs. It recognises the X, Y and Z sync patterns by their 8-half-slot shape.

Decoded subframes are 32 slots long. The framer checks even parity and checks that sync patterns come in the expected order: a left subframe (X, or Z at a block start) must be followed by a right subframe (Y). It also checks that a Z arrives exactly every 192 frames. A completed pair is presented on the output registers with its validity, user and channel-status bits, and `ready_o` is raised. Software consumes the pair with a one-cycle `rd_i` pulse. The same pulse clears the sticky error flags. The block does not compute a CRC over the channel-status bits.

Top module: `spdif_rx`

## Requirements
- R1: A run between line transitions is rounded to the nearest whole number of half slots, using `half_len_i` samples per half slot. Any setting of 2 or more decodes correctly. A data slot that carries a transition only at its start is a 0; a slot with a second transition in its middle is a 1.
- R2: Subframe slots 0..3 are the sync pattern. The patterns, MSB first and starting after a transition from a low level, are X=11100010, Y=11100100 and Z=11101000; their inverses are also accepted. Slots 4..27 carry the PCM sample LSB first. Slot 28 is validity, slot 29 is user and slot 30 is channel status; they appear on `*_vuc_o` as bit0, bit1 and bit2.
- R3: When a Y subframe completes after an X or Z subframe, the pair appears on `left_o`/`right_o` and `ready_o` goes to 1. `blk_start_o` is 1 when the left sample came from a Z subframe.
- R4: Slot 31 makes slots 4..31 even parity. A violation in an X/Z subframe sets `lpar_err_o`, and one in a Y subframe sets `rpar_err_o`. The pair is still delivered.
- R5: Inside a subframe, a run that is not a legal data-slot run, or a sync pattern of unknown shape, sets `bip_err_o`. The pair in progress is discarded. The receiver resynchronises on the next sync pattern without reporting a frame error.
- R6: An X/Z subframe that follows an X/Z subframe, or a Y subframe that follows a Y subframe, sets `frame_err_o`.
- R7: Once a Z has been seen, `block_err_o` is set in two cases: the next Z arrives after a frame count other than 192, or an X arrives where the Z of the 193rd frame was due.
- R8: If a new pair is delivered while `ready_o` is still 1 and `rd_i` is low, the new pair replaces the old one and `miss_o` is set.
- R9: A one-cycle `rd_i` pulse clears `ready_o` and all six error flags. Flags are otherwise sticky.
- R10: After reset, `ready_o` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_len_i | input | HALF_W | Clock samples per half slot |
| line_i | input | 1 | Serial S/PDIF line |
| rd_i | input | 1 | Read pulse: consume pair, clear flags |
| ready_o | output | 1 | Unread sample pair present |
| left_o | output | 24 | Left PCM sample |
| right_o | output | 24 | Right PCM sample |
| left_vuc_o | output | 3 | Left {channel status, user, validity} |
| right_vuc_o | output | 3 | Right {channel status, user, validity} |
| blk_start_o | output | 1 | Left sample opened a 192-frame block |
| lpar_err_o | output | 1 | Left parity error (sticky) |
| rpar_err_o | output | 1 | Right parity error (sticky) |
| bip_err_o | output | 1 | Biphase coding error (sticky) |
| frame_err_o | output | 1 | Subframe order error (sticky) |
| block_err_o | output | 1 | Block period error (sticky) |
| miss_o | output | 1 | Unread pair was overwritten (sticky) |

## Verification
The assertions assume that `half_len_i` stays at 2 or more and changes only while reset is held. They also assume that `rd_i` is a single-cycle pulse. Given these, a sample pair or an error can only appear right after a subframe ends, and the decoder never reports two events in one cycle. The stimulus builds each half slot as exactly `half_len_i` samples, driven on the falling clock edge. It changes the rate only under reset and holds the line idle before the first sync pattern, so the first measured run is too long and is ignored. Deliberate faults are limited to flipped parity, a missing slot-boundary transition, and reordered or mistimed sync patterns.

// File: rtl/spdif_rx_pkg.sv
package spdif_rx_pkg;
  typedef enum logic [1:0] {PRE_X = 2'd0, PRE_Y = 2'd1, PRE_Z = 2'd2, PRE_NONE = 2'd3} pre_e;
  localparam int PCM_W     = 24;
  localparam int WORD_W    = 28;  // slots 4..31
  localparam int LAST_SLOT = 31;
  localparam logic [7:0] PAT_X = 8'b11100010;
  localparam logic [7:0] PAT_Y = 8'b11100100;
  localparam logic [7:0] PAT_Z = 8'b11101000;
endpackage

// File: rtl/spdif_run_meter.sv
module spdif_run_meter #(
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic [HALF_W-1:0] half_len_i,
  output logic              run_vld_o,
  output logic [1:0]        run_n_o    // 0 = illegal length
);
  localparam int CNT_W = HALF_W + 3;

  logic             s1_q, s2_q, s3_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   hx, two_cnt, lim1, lim2, lim3;
  logic [1:0]       cls;
  logic             edge_w;

  assign edge_w  = s2_q ^ s3_q;
  assign hx      = {{(CNT_W+1-HALF_W){1'b0}}, half_len_i};
  assign two_cnt = {cnt_q, 1'b0};
  assign lim1    = hx + (hx << 1);
  assign lim2    = (hx << 2) + hx;
  assign lim3    = (hx << 3) - hx;

  always_comb begin
    if (two_cnt < hx)        cls = 2'd0;
    else if (two_cnt < lim1) cls = 2'd1;
    else if (two_cnt < lim2) cls = 2'd2;
    else if (two_cnt < lim3) cls = 2'd3;
    else                     cls = 2'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q      <= 1'b0;
      s2_q      <= 1'b0;
      s3_q      <= 1'b0;
      cnt_q     <= '1;
      run_vld_o <= 1'b0;
      run_n_o   <= 2'd0;
    end else begin
      s1_q      <= line_i;
      s2_q      <= s1_q;
      s3_q      <= s2_q;
      run_vld_o <= edge_w;
      run_n_o   <= cls;
      if (edge_w)           cnt_q <= CNT_W'(1);
      else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spdif_slot_dec.sv
module spdif_slot_dec
  import spdif_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_vld_i,
  input  logic [1:0] run_n_i,
  output logic       pre_vld_o,
  output pre_e       pre_type_o,
  output logic       bit_vld_o,
  output logic       bit_val_o,
  output logic       bit_last_o,
  output logic       bip_err_o
);
  typedef enum logic [2:0] {S_HUNT, S_PRE, S_DAT_A, S_DAT_B, S_WAIT} st_e;

  st_e        st_q;
  logic [7:0] pat_q, app_pat, fill;
  logic [3:0] psum_q, sum_n;
  logic       lvl_q;
  logic [4:0] slot_q;

  assign sum_n   = psum_q + {2'b00, run_n_i};
  assign fill    = lvl_q ? ((8'd1 << run_n_i) - 8'd1) : 8'd0;
  assign app_pat = (pat_q << run_n_i) | fill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_HUNT;
      pat_q      <= '0;
      psum_q     <= '0;
      lvl_q      <= 1'b0;
      slot_q     <= '0;
      pre_vld_o  <= 1'b0;
      pre_type_o <= PRE_NONE;
      bit_vld_o  <= 1'b0;
      bit_val_o  <= 1'b0;
      bit_last_o <= 1'b0;
      bip_err_o  <= 1'b0;
    end else begin
      pre_vld_o  <= 1'b0;
      bit_vld_o  <= 1'b0;
      bit_last_o <= 1'b0;
      bip_err_o  <= 1'b0;
      if (run_vld_i) begin
        unique case (st_q)
          S_HUNT: if (run_n_i == 2'd3) begin
            st_q <= S_PRE; pat_q <= 8'b0000_0111; psum_q <= 4'd3; lvl_q <= 1'b0;
          end
          S_PRE: begin
            if (run_n_i == 2'd0 || sum_n > 4'd8) begin
              bip_err_o <= 1'b1; st_q <= S_HUNT;
            end else begin
              pat_q  <= app_pat;
              psum_q <= sum_n;
              lvl_q  <= ~lvl_q;
              if (sum_n == 4'd8) begin
                st_q   <= S_DAT_A;
                slot_q <= 5'd4;
                unique case (app_pat)
                  PAT_X:   begin pre_vld_o <= 1'b1; pre_type_o <= PRE_X; end
                  PAT_Y:   begin pre_vld_o <= 1'b1; pre_type_o <= PRE_Y; end
                  PAT_Z:   begin pre_vld_o <= 1'b1; pre_type_o <= PRE_Z; end
                  default: begin bip_err_o <= 1'b1; st_q <= S_HUNT; end
                endcase
              end
            end
          end
          S_DAT_A, S_DAT_B, S_WAIT: begin
            if (st_q == S_DAT_A && run_n_i == 2'd1) begin
              st_q <= S_DAT_B;
            end else if ((st_q == S_DAT_A && run_n_i == 2'd2) ||
                         (st_q == S_DAT_B && run_n_i == 2'd1)) begin
              bit_vld_o  <= 1'b1;
              bit_val_o  <= (st_q == S_DAT_B);
              bit_last_o <= (slot_q == 5'(LAST_SLOT));
              slot_q     <= slot_q + 1'b1;
              st_q       <= (slot_q == 5'(LAST_SLOT)) ? S_WAIT : S_DAT_A;
            end else if (run_n_i == 2'd3) begin
              // start of a sync pattern; an error unless one was due
              bip_err_o <= (st_q != S_WAIT);
              st_q <= S_PRE; pat_q <= 8'b0000_0111; psum_q <= 4'd3; lvl_q <= 1'b0;
            end else begin
              bip_err_o <= 1'b1; st_q <= S_HUNT;
            end
          end
          default: st_q <= S_HUNT;
        endcase
      end
    end
  end

  p_one_event_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pre_vld_o, bit_vld_o, bip_err_o}));
  p_last_is_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_last_o |-> bit_vld_o);
endmodule

// File: rtl/spdif_framer.sv
module spdif_framer
  import spdif_rx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_vld_i,
  input  pre_e             pre_type_i,
  input  logic             bit_vld_i,
  input  logic             bit_val_i,
  input  logic             bit_last_i,
  input  logic             bip_err_i,
  input  logic             rd_i,
  output logic             ready_o,
  output logic [PCM_W-1:0] left_o,
  output logic [PCM_W-1:0] right_o,
  output logic [2:0]       left_vuc_o,
  output logic [2:0]       right_vuc_o,
  output logic             blk_start_o,
  output logic             lpar_err_o,
  output logic             rpar_err_o,
  output logic             bip_err_o,
  output logic             frame_err_o,
  output logic             block_err_o,
  output logic             miss_o
);
  localparam int BW = $clog2(BLOCK_FRAMES + 1);
  localparam logic [BW-1:0] BLK_N = BW'(BLOCK_FRAMES);

  pre_e              cur_q;
  logic [WORD_W-1:0] sr_q, nxt;
  logic [PCM_W-1:0]  l_data_q;
  logic [2:0]        l_vuc_q;
  logic              l_z_q, l_ok_q, have_prev_q, exp_y_q, z_seen_q;
  logic [BW-1:0]     blk_cnt_q;

  assign nxt = {bit_val_i, sr_q[WORD_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= PRE_NONE; sr_q <= '0;
      l_data_q <= '0; l_vuc_q <= '0; l_z_q <= 1'b0; l_ok_q <= 1'b0;
      have_prev_q <= 1'b0; exp_y_q <= 1'b0; z_seen_q <= 1'b0; blk_cnt_q <= '0;
      ready_o <= 1'b0; left_o <= '0; right_o <= '0;
      left_vuc_o <= '0; right_vuc_o <= '0; blk_start_o <= 1'b0;
      lpar_err_o <= 1'b0; rpar_err_o <= 1'b0; bip_err_o <= 1'b0;
      frame_err_o <= 1'b0; block_err_o <= 1'b0; miss_o <= 1'b0;
    end else begin
      if (rd_i) begin
        ready_o <= 1'b0;
        lpar_err_o <= 1'b0; rpar_err_o <= 1'b0; bip_err_o <= 1'b0;
        frame_err_o <= 1'b0; block_err_o <= 1'b0; miss_o <= 1'b0;
      end
      if (pre_vld_i) cur_q <= pre_type_i;
      if (bit_vld_i) sr_q <= nxt;
      if (bip_err_i) begin
        bip_err_o   <= 1'b1;
        have_prev_q <= 1'b0;
        l_ok_q      <= 1'b0;
      end
      if (bit_last_i) begin
        have_prev_q <= 1'b1;
        if (cur_q == PRE_Y) begin
          if (have_prev_q && !exp_y_q) frame_err_o <= 1'b1;
          exp_y_q <= 1'b0;
          if (^nxt) rpar_err_o <= 1'b1;
          if (l_ok_q) begin
            l_ok_q      <= 1'b0;
            left_o      <= l_data_q;
            left_vuc_o  <= l_vuc_q;
            blk_start_o <= l_z_q;
            right_o     <= nxt[PCM_W-1:0];
            right_vuc_o <= nxt[PCM_W+2:PCM_W];
            if (ready_o && !rd_i) miss_o <= 1'b1;
            ready_o     <= 1'b1;
          end
        end else begin
          if (have_prev_q && exp_y_q) frame_err_o <= 1'b1;
          exp_y_q  <= 1'b1;
          if (^nxt) lpar_err_o <= 1'b1;
          l_data_q <= nxt[PCM_W-1:0];
          l_vuc_q  <= nxt[PCM_W+2:PCM_W];
          l_z_q    <= (cur_q == PRE_Z);
          l_ok_q   <= 1'b1;
          if (cur_q == PRE_Z) begin
            if (z_seen_q && blk_cnt_q != BLK_N) block_err_o <= 1'b1;
            z_seen_q  <= 1'b1;
            blk_cnt_q <= BW'(1);
          end else if (z_seen_q) begin
            if (blk_cnt_q == BLK_N) begin
              block_err_o <= 1'b1;
              z_seen_q    <= 1'b0;
            end else begin
              blk_cnt_q <= blk_cnt_q + 1'b1;
            end
          end
        end
      end
    end
  end

  p_ready_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(bit_last_i));
  p_lpar_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lpar_err_o) |-> $past(bit_last_i));
  p_frame_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> $past(bit_last_i));
  p_block_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(block_err_o) |-> $past(bit_last_i));
  p_miss_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miss_o) |-> $past(ready_o));
  p_rd_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !bit_last_i) |=> !ready_o);
endmodule

// File: rtl/spdif_rx.sv
module spdif_rx
  import spdif_rx_pkg::*;
#(
  parameter int HALF_W       = 8,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] half_len_i,
  input  logic              line_i,
  input  logic              rd_i,
  output logic              ready_o,
  output logic [23:0]       left_o,
  output logic [23:0]       right_o,
  output logic [2:0]        left_vuc_o,
  output logic [2:0]        right_vuc_o,
  output logic              blk_start_o,
  output logic              lpar_err_o,
  output logic              rpar_err_o,
  output logic              bip_err_o,
  output logic              frame_err_o,
  output logic              block_err_o,
  output logic              miss_o
);
  logic       run_vld;
  logic [1:0] run_n;
  logic       pre_vld, bit_vld, bit_val, bit_last, bip_ev;
  pre_e       pre_type;

  spdif_run_meter #(.HALF_W(HALF_W)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .half_len_i(half_len_i),
    .run_vld_o(run_vld), .run_n_o(run_n)
  );

  spdif_slot_dec u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_vld_i(run_vld), .run_n_i(run_n),
    .pre_vld_o(pre_vld), .pre_type_o(pre_type), .bit_vld_o(bit_vld),
    .bit_val_o(bit_val), .bit_last_o(bit_last), .bip_err_o(bip_ev)
  );

  spdif_framer #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_frm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pre_vld_i(pre_vld), .pre_type_i(pre_type),
    .bit_vld_i(bit_vld), .bit_val_i(bit_val), .bit_last_i(bit_last),
    .bip_err_i(bip_ev), .rd_i(rd_i), .ready_o(ready_o), .left_o(left_o),
    .right_o(right_o), .left_vuc_o(left_vuc_o), .right_vuc_o(right_vuc_o),
    .blk_start_o(blk_start_o), .lpar_err_o(lpar_err_o), .rpar_err_o(rpar_err_o),
    .bip_err_o(bip_err_o), .frame_err_o(frame_err_o), .block_err_o(block_err_o),
    .miss_o(miss_o)
  );

  p_half_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(half_len_i));
endmodule

// File: tb/sim_spdif_rx.sv
module sim_spdif_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_len = 8'd2;
  logic        line = 1'b0;
  logic        rd = 1'b0;
  logic        ready, blk_start, lpar, rpar, bip, frm, blk, miss;
  logic [23:0] left, right;
  logic [2:0]  lvuc, rvuc;
  int          total = 0;
  int          bad = 0;

  localparam logic [7:0] SX = 8'b11100010;
  localparam logic [7:0] SY = 8'b11100100;
  localparam logic [7:0] SZ = 8'b11101000;

  always #5 clk = ~clk;

  spdif_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .half_len_i(half_len), .line_i(line), .rd_i(rd),
    .ready_o(ready), .left_o(left), .right_o(right), .left_vuc_o(lvuc),
    .right_vuc_o(rvuc), .blk_start_o(blk_start), .lpar_err_o(lpar),
    .rpar_err_o(rpar), .bip_err_o(bip), .frame_err_o(frm),
    .block_err_o(blk), .miss_o(miss)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] h);
    @(negedge clk);
    rst_n = 1'b0; rd = 1'b0; half_len = h;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic send_half(input logic lv);
    line = lv;
    repeat (int'(half_len)) @(negedge clk);
  endtask

  task automatic send_sub(input logic [7:0] pat, input logic [23:0] pcm,
                          input logic [2:0] vuc, input logic bad_par, input int corrupt);
    logic [27:0] w;
    logic        inv, first;
    w[23:0]  = pcm;
    w[26:24] = vuc;
    w[27]    = (^w[26:0]) ^ bad_par;
    inv = line;
    for (int k = 7; k >= 0; k--) send_half(pat[k] ^ inv);
    for (int s = 0; s < 28; s++) begin
      first = (s + 4 == corrupt) ? line : ~line;
      send_half(first);
      send_half(w[s] ? ~first : first);
    end
  endtask

  task automatic send_frame(input logic [7:0] lp, input logic [23:0] l, input logic [23:0] r,
                            input logic [2:0] lv, input logic [2:0] rv,
                            input logic bl, input logic br);
    send_sub(lp, l, lv, bl, -1);
    send_sub(SY, r, rv, br, -1);
  endtask

  task automatic tail;
    send_half(~line);
    repeat (12) @(negedge clk);
  endtask

  task automatic do_read;
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(8'd2);
    chk("R10 ready", ready, 0);
    chk("R10 flags", {lpar, rpar, bip, frm, blk, miss}, 0);
  endtask

  task automatic t_pair;
    do_reset(8'd2);
    send_frame(SZ, 24'h123456, 24'hABCDEF, 3'b101, 3'b010, 1'b0, 1'b0);
    tail();
    chk("R3 ready", ready, 1);
    chk("R2 left", left, 32'h123456);
    chk("R2 right", right, 32'hABCDEF);
    chk("R2 left vuc", lvuc, 3'b101);
    chk("R2 right vuc", rvuc, 3'b010);
    chk("R3 block start", blk_start, 1);
    chk("R4 no parity err", {lpar, rpar, bip, frm, blk, miss}, 0);
    do_read();
    chk("R9 read clears ready", ready, 0);
  endtask

  task automatic t_rate;
    do_reset(8'd3);
    send_frame(SX, 24'h800001, 24'h7FFFFE, 3'b011, 3'b100, 1'b0, 1'b0);
    tail();
    chk("R1 left at rate 3", left, 32'h800001);
    chk("R1 right at rate 3", right, 32'h7FFFFE);
    chk("R3 x not block start", blk_start, 0);
    chk("R1 no errors at rate 3", {lpar, rpar, bip, frm, blk, miss}, 0);
  endtask

  task automatic t_parity;
    do_reset(8'd2);
    send_frame(SX, 24'h00F00F, 24'h000001, 3'b000, 3'b000, 1'b1, 1'b0);
    tail();
    chk("R4 left parity", {lpar, rpar}, 2'b10);
    chk("R4 pair still delivered", ready, 1);
    do_read();
    chk("R9 flags cleared", {lpar, rpar, bip, frm, blk, miss, ready}, 0);
    send_frame(SX, 24'h000003, 24'h0A0A0A, 3'b000, 3'b001, 1'b0, 1'b1);
    tail();
    chk("R4 right parity", {lpar, rpar}, 2'b01);
  endtask

  task automatic t_biphase;
    do_reset(8'd2);
    send_sub(SX, 24'h000000, 3'b000, 1'b0, 10);
    send_sub(SY, 24'h111111, 3'b000, 1'b0, -1);
    send_frame(SZ, 24'h2468AC, 24'h13579B, 3'b001, 3'b001, 1'b0, 1'b0);
    tail();
    chk("R5 biphase flag", bip, 1);
    chk("R5 no frame err on resync", frm, 0);
    chk("R5 resync pair left", left, 32'h2468AC);
    chk("R5 resync pair right", right, 32'h13579B);
    chk("R5 broken pair not counted", miss, 0);
  endtask

  task automatic t_frame;
    do_reset(8'd2);
    send_sub(SX, 24'h000011, 3'b000, 1'b0, -1);
    send_sub(SX, 24'h000022, 3'b000, 1'b0, -1);
    send_sub(SY, 24'h000033, 3'b000, 1'b0, -1);
    tail();
    chk("R6 missing y", frm, 1);
    chk("R6 later left kept", left, 32'h000022);
    do_reset(8'd2);
    send_frame(SZ, 24'h000044, 24'h000055, 3'b000, 3'b000, 1'b0, 1'b0);
    send_sub(SY, 24'h000066, 3'b000, 1'b0, -1);
    tail();
    chk("R6 orphan y", frm, 1);
    chk("R6 pair before orphan", right, 32'h000055);
  endtask

  task automatic t_miss;
    do_reset(8'd2);
    send_frame(SX, 24'h0000A1, 24'h0000B1, 3'b000, 3'b000, 1'b0, 1'b0);
    send_frame(SX, 24'h0000A2, 24'h0000B2, 3'b000, 3'b000, 1'b0, 1'b0);
    tail();
    chk("R8 miss set", miss, 1);
    chk("R8 newest left", left, 32'h0000A2);
    do_read();
    chk("R9 miss cleared", {miss, ready}, 0);
  endtask

  task automatic t_block_early;
    do_reset(8'd2);
    send_frame(SZ, 24'h1, 24'h1, 3'b000, 3'b000, 1'b0, 1'b0);
    for (int f = 0; f < 4; f++) send_frame(SX, 24'h2, 24'h2, 3'b000, 3'b000, 1'b0, 1'b0);
    send_frame(SZ, 24'h3, 24'h3, 3'b000, 3'b000, 1'b0, 1'b0);
    tail();
    chk("R7 early z", blk, 1);
  endtask

  task automatic t_block_full;
    do_reset(8'd2);
    send_frame(SZ, 24'h1, 24'h1, 3'b000, 3'b000, 1'b0, 1'b0);
    for (int f = 0; f < 191; f++) send_frame(SX, 24'h0, 24'h0, 3'b000, 3'b000, 1'b0, 1'b0);
    send_frame(SZ, 24'h5, 24'h6, 3'b000, 3'b000, 1'b0, 1'b0);
    chk("R7 z on time", blk, 0);
    for (int f = 0; f < 191; f++) send_frame(SX, 24'h0, 24'h0, 3'b000, 3'b000, 1'b0, 1'b0);
    chk("R7 no err before due", blk, 0);
    send_frame(SX, 24'h7, 24'h8, 3'b000, 3'b000, 1'b0, 1'b0);
    tail();
    chk("R7 missing z", blk, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pair();
        t_rate();
        t_parity();
        t_biphase();
        t_frame();
        t_miss();
        t_block_early();
        t_block_full();
      end
      begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule